// File: doc/BRIEF.md
# Virtual UART Register and Interrupt Block

This block is the register front end of a UART-style console that has no serial line. A guest-side bus master reads and writes a small set of word-aligned registers. Behind the data register sit two byte queues. The receive queue is filled by a host-side agent and emptied by guest reads. The transmit queue is filled by guest writes and emptied by the host agent. Status flags and raw interrupt bits are not derived from serial timing. Instead they are stored bits, and they change on queue events from either side.

The guest sees a level interrupt, which is the OR of raw status AND mask. The host sees a one-cycle doorbell. The doorbell fires only when a guest write takes the transmit queue from empty to one byte. The host side uses two byte streams with valid/ready handshakes. On the receive push port, `rx_ready` is high while the receive queue has room. The host may hold `rx_valid` and `rx_data` as long as it likes, and a byte is taken on the cycle both are high. On the transmit pop port, `tx_valid` is high while the queue holds a byte, and `tx_data` shows the oldest byte. That byte is removed on the cycle both `tx_valid` and `tx_ready` are high.

A bus access is one cycle: `bus_sel` with `bus_wr` and `bus_addr`. Read data on `bus_rdata` is combinational during the access. Side effects, such as a queue pop on a data read, take place at the closing clock edge.

Top module: `vcon_uart`

## Requirements
- R1: After reset, every register reads zero (flag, raw, mask, masked, control), `guest_irq` and `host_bell` are 0, `rx_ready` is 1 and `tx_valid` is 0.
- R2: The control register at offset 0x030 is plain storage of its low 16 bits; bits 31:16 read as zero.
- R3: Offsets 0x004 (receive status), 0x044 (interrupt clear) and 0x048 (DMA control) read zero, as does any unmapped offset. Writes to 0x018 (flag), 0x03C (raw), 0x040 (masked), 0x048 and unmapped offsets change nothing.
- R4: A guest write to data offset 0x000 queues the byte only if the transmit queue is not full. Every such write sets BUSY (flag bit 3) and clears transmit-empty (bit 7). If the queue is full afterwards, transmit-full (bit 5) is set and raw transmit bit 5 is cleared.
- R5: A guest read of offset 0x000 returns the oldest received byte and removes it, or returns zero when the queue is empty. Every such read clears receive-full (flag bit 6). If the queue is then empty, receive-empty (bit 4) is set and raw receive bit 4 is cleared.
- R6: On any host handshake cycle (push or pop), the block updates flags from the occupancy after that cycle:
  - A non-empty receive queue clears bit 4, sets raw bit 4, and also sets bit 6 when the queue is full.
  - A transmit queue that is not full clears bit 5 and sets raw bit 5.
  - An empty transmit queue also clears bit 3 and sets bit 7.
- R7: The masked status at 0x040 reads raw (0x03C) AND mask (0x038, 11 bits). `guest_irq` is high exactly when that value is nonzero, including in the cycle after a mask write.
- R8: A write to 0x044 clears each raw bit that is 1 in the written value.
- R9: `host_bell` is high for exactly one cycle, the cycle after a guest write that takes the transmit queue from empty to one byte. It stays low for all other writes.
- R10: Both queues deliver bytes in arrival order. `rx_ready` is high iff the receive queue is not full, and `tx_valid` is high iff the transmit queue is not empty.
- R11: The receive queue holds 2^RX_AW-1 bytes (1023 by default) and the transmit queue holds 2^TX_AW-1 bytes (2047 by default).
- R12: When a guest access and a host handshake fall in the same cycle, the guest's flag effects are applied first and the host update second.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_sel | input | 1 | Guest register access this cycle |
| bus_wr | input | 1 | 1 write, 0 read |
| bus_addr | input | 12 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the current access |
| rx_valid | input | 1 | Host offers a receive byte |
| rx_data | input | 8 | Receive byte |
| rx_ready | output | 1 | Receive queue has room |
| tx_valid | output | 1 | Transmit byte available |
| tx_data | output | 8 | Oldest transmit byte |
| tx_ready | input | 1 | Host takes the transmit byte |
| guest_irq | output | 1 | Level interrupt to guest |
| host_bell | output | 1 | One-cycle doorbell to host |

## Verification
The flag and raw bits are stored state, not a live function of occupancy. A wrong update therefore persists and shows up at the next flag or raw read, and at `guest_irq`, in the cycle right after the offending edge. An occupancy counter error shows up as a wrong `rx_ready` or `tx_valid` at a queue boundary, or as a byte out of sequence on `tx_data` or a data read. Filling and draining both queues to their limits exposes these errors. A lost guest or host priority in the shared cycle leaves the receive-empty bit set although a byte waits.

// File: rtl/vcon_pkg.sv
package vcon_pkg;
  localparam int unsigned OFS_W  = 12;
  localparam int unsigned IRQ_W  = 11;
  localparam int unsigned CTRL_W = 16;

  localparam logic [OFS_W-1:0] OFS_DATA  = 12'h000;
  localparam logic [OFS_W-1:0] OFS_RSTAT = 12'h004;
  localparam logic [OFS_W-1:0] OFS_FLAG  = 12'h018;
  localparam logic [OFS_W-1:0] OFS_CTRL  = 12'h030;
  localparam logic [OFS_W-1:0] OFS_MASK  = 12'h038;
  localparam logic [OFS_W-1:0] OFS_RAW   = 12'h03C;
  localparam logic [OFS_W-1:0] OFS_MIS   = 12'h040;
  localparam logic [OFS_W-1:0] OFS_ICLR  = 12'h044;
  localparam logic [OFS_W-1:0] OFS_DMA   = 12'h048;

  localparam int FB_BUSY = 3;
  localparam int FB_RXE  = 4;
  localparam int FB_TXF  = 5;
  localparam int FB_RXF  = 6;
  localparam int FB_TXE  = 7;

  localparam int IB_RX = 4;
  localparam int IB_TX = 5;

  typedef enum logic [3:0] {
    SEL_NONE, SEL_DATA, SEL_RSTAT, SEL_FLAG, SEL_CTRL,
    SEL_MASK, SEL_RAW, SEL_MIS, SEL_ICLR, SEL_DMA
  } reg_sel_e;

  function automatic reg_sel_e decode_ofs(input logic [OFS_W-1:0] a);
    case (a)
      OFS_DATA:  return SEL_DATA;
      OFS_RSTAT: return SEL_RSTAT;
      OFS_FLAG:  return SEL_FLAG;
      OFS_CTRL:  return SEL_CTRL;
      OFS_MASK:  return SEL_MASK;
      OFS_RAW:   return SEL_RAW;
      OFS_MIS:   return SEL_MIS;
      OFS_ICLR:  return SEL_ICLR;
      OFS_DMA:   return SEL_DMA;
      default:   return SEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/vcon_ring.sv
module vcon_ring #(
  parameter int unsigned AW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [7:0]    push_data,
  input  logic          pop,
  output logic [7:0]    pop_data,
  output logic          empty,
  output logic          full,
  output logic          empty_nxt,
  output logic          full_nxt
);
  localparam int unsigned SIZE = 1 << AW;
  localparam logic [AW-1:0] MAXC = {AW{1'b1}};

  logic [7:0]    mem [SIZE];
  logic [AW-1:0] prod_q, cons_q, cnt, cnt_nxt;

  assign cnt       = prod_q - cons_q;
  assign cnt_nxt   = cnt + AW'(push) - AW'(pop);
  assign empty     = (cnt == '0);
  assign full      = (cnt == MAXC);
  assign empty_nxt = (cnt_nxt == '0);
  assign full_nxt  = (cnt_nxt == MAXC);
  assign pop_data  = mem[cons_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prod_q <= '0;
      cons_q <= '0;
    end else begin
      if (push) prod_q <= prod_q + 1'b1;
      if (pop)  cons_q <= cons_q + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[prod_q] <= push_data;
  end

  // R10
  ring_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  // R10
  ring_no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/vcon_status.sv
module vcon_status
  import vcon_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_wr,
  input  logic             tx_push,
  input  logic             tx_empty,
  input  logic             rx_rd,
  input  logic             clr_we,
  input  logic [IRQ_W-1:0] clr_bits,
  input  logic             host_evt,
  input  logic             rx_empty_nxt,
  input  logic             rx_full_nxt,
  input  logic             tx_empty_nxt,
  input  logic             tx_full_nxt,
  output logic [7:0]       flag_q,
  output logic [IRQ_W-1:0] raw_q,
  output logic             bell_q
);
  logic [7:0]       flag_d;
  logic [IRQ_W-1:0] raw_d;

  always_comb begin
    flag_d = flag_q;
    raw_d  = raw_q;
    // guest effects first
    if (tx_wr) begin
      flag_d[FB_BUSY] = 1'b1;
      flag_d[FB_TXE]  = 1'b0;
      if (tx_full_nxt) begin
        flag_d[FB_TXF] = 1'b1;
        raw_d[IB_TX]   = 1'b0;
      end
    end
    if (rx_rd) begin
      flag_d[FB_RXF] = 1'b0;
      if (rx_empty_nxt) begin
        flag_d[FB_RXE] = 1'b1;
        raw_d[IB_RX]   = 1'b0;
      end
    end
    if (clr_we) raw_d = raw_d & ~clr_bits;
    // host update second
    if (host_evt) begin
      if (!rx_empty_nxt) begin
        flag_d[FB_RXE] = 1'b0;
        raw_d[IB_RX]   = 1'b1;
        if (rx_full_nxt) flag_d[FB_RXF] = 1'b1;
      end
      if (!tx_full_nxt) begin
        flag_d[FB_TXF] = 1'b0;
        raw_d[IB_TX]   = 1'b1;
        if (tx_empty_nxt) begin
          flag_d[FB_BUSY] = 1'b0;
          flag_d[FB_TXE]  = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      raw_q  <= '0;
      bell_q <= 1'b0;
    end else begin
      flag_q <= flag_d;
      raw_q  <= raw_d;
      bell_q <= tx_push && tx_empty;
    end
  end

  // R4
  busy_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_wr |=> (flag_q[FB_BUSY] && !flag_q[FB_TXE]));
  // R5
  rd_clears_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd && !host_evt) |=> !flag_q[FB_RXF]);
  // R8
  clear_bits_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_we && !host_evt) |=> ((raw_q & $past(clr_bits)) == '0));
  // R9
  bell_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bell_q |=> !bell_q);
  // R6
  host_rx_seen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (host_evt && !rx_empty_nxt) |=> (!flag_q[FB_RXE] && raw_q[IB_RX]));
endmodule

// File: rtl/vcon_uart.sv
module vcon_uart
  import vcon_pkg::*;
#(
  parameter int unsigned RX_AW = 10,
  parameter int unsigned TX_AW = 11
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        bus_sel,
  input  logic        bus_wr,
  input  logic [11:0] bus_addr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  input  logic        rx_valid,
  input  logic [7:0]  rx_data,
  output logic        rx_ready,
  output logic        tx_valid,
  output logic [7:0]  tx_data,
  input  logic        tx_ready,
  output logic        guest_irq,
  output logic        host_bell
);
  reg_sel_e sel;
  logic g_wr, g_rd, tx_wr, rx_rd, tx_push, rx_pop, rx_push, tx_pop, host_evt;
  logic rx_empty, rx_full, rx_empty_nxt, rx_full_nxt;
  logic tx_empty, tx_full, tx_empty_nxt, tx_full_nxt;
  logic [7:0]        rx_head;
  logic [7:0]        flag_q;
  logic [IRQ_W-1:0]  raw_q, mask_q, mis;
  logic [CTRL_W-1:0] ctrl_q;

  assign sel      = decode_ofs(bus_addr);
  assign g_wr     = bus_sel && bus_wr;
  assign g_rd     = bus_sel && !bus_wr;
  assign tx_wr    = g_wr && (sel == SEL_DATA);
  assign rx_rd    = g_rd && (sel == SEL_DATA);
  assign tx_push  = tx_wr && !tx_full;
  assign rx_pop   = rx_rd && !rx_empty;
  assign rx_ready = !rx_full;
  assign tx_valid = !tx_empty;
  assign rx_push  = rx_valid && rx_ready;
  assign tx_pop   = tx_valid && tx_ready;
  assign host_evt = rx_push || tx_pop;
  assign mis      = raw_q & mask_q;
  assign guest_irq = |mis;

  vcon_ring #(.AW(RX_AW)) u_rx_ring (
    .clk(clk), .rst_n(rst_n),
    .push(rx_push), .push_data(rx_data),
    .pop(rx_pop), .pop_data(rx_head),
    .empty(rx_empty), .full(rx_full),
    .empty_nxt(rx_empty_nxt), .full_nxt(rx_full_nxt)
  );

  vcon_ring #(.AW(TX_AW)) u_tx_ring (
    .clk(clk), .rst_n(rst_n),
    .push(tx_push), .push_data(bus_wdata[7:0]),
    .pop(tx_pop), .pop_data(tx_data),
    .empty(tx_empty), .full(tx_full),
    .empty_nxt(tx_empty_nxt), .full_nxt(tx_full_nxt)
  );

  vcon_status u_status (
    .clk(clk), .rst_n(rst_n),
    .tx_wr(tx_wr), .tx_push(tx_push), .tx_empty(tx_empty),
    .rx_rd(rx_rd),
    .clr_we(g_wr && (sel == SEL_ICLR)), .clr_bits(bus_wdata[IRQ_W-1:0]),
    .host_evt(host_evt),
    .rx_empty_nxt(rx_empty_nxt), .rx_full_nxt(rx_full_nxt),
    .tx_empty_nxt(tx_empty_nxt), .tx_full_nxt(tx_full_nxt),
    .flag_q(flag_q), .raw_q(raw_q), .bell_q(host_bell)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      mask_q <= '0;
    end else if (g_wr) begin
      if (sel == SEL_CTRL) ctrl_q <= bus_wdata[CTRL_W-1:0];
      if (sel == SEL_MASK) mask_q <= bus_wdata[IRQ_W-1:0];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (g_rd) begin
      unique case (sel)
        SEL_DATA: bus_rdata = rx_empty ? 32'h0 : {24'h0, rx_head};
        SEL_FLAG: bus_rdata = {24'h0, flag_q};
        SEL_CTRL: bus_rdata = {{(32-CTRL_W){1'b0}}, ctrl_q};
        SEL_MASK: bus_rdata = {{(32-IRQ_W){1'b0}}, mask_q};
        SEL_RAW:  bus_rdata = {{(32-IRQ_W){1'b0}}, raw_q};
        SEL_MIS:  bus_rdata = {{(32-IRQ_W){1'b0}}, mis};
        default:  bus_rdata = '0;
      endcase
    end
  end

  // R5
  empty_read_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_rd && rx_empty) |-> (bus_rdata == 32'h0));
  // R7
  irq_after_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (g_wr && (sel == SEL_MASK) && !host_evt) |=>
      (guest_irq == |($past(bus_wdata[IRQ_W-1:0]) & raw_q)));
endmodule

// File: tb/vcon_uart_bench.sv
module vcon_uart_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [11:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic        rx_valid = 1'b0, rx_ready, tx_valid, tx_ready = 1'b0;
  logic [7:0]  rx_data = '0, tx_data;
  logic        guest_irq, host_bell;
  int n_checks = 0, n_fail = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  vcon_uart u_vcon_uart (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
    .tx_valid(tx_valid), .tx_data(tx_data), .tx_ready(tx_ready),
    .guest_irq(guest_irq), .host_bell(host_bell)
  );

  // {req, wr, addr, wdata, expected read}
  localparam int NV = 22;
  localparam logic [80:0] VECS [NV] = '{
    {4'd1, 1'b0, 12'h030, 32'h0, 32'h0},        // R1 control
    {4'd1, 1'b0, 12'h018, 32'h0, 32'h0},        // R1 flag
    {4'd1, 1'b0, 12'h03C, 32'h0, 32'h0},        // R1 raw
    {4'd1, 1'b0, 12'h038, 32'h0, 32'h0},        // R1 mask
    {4'd1, 1'b0, 12'h040, 32'h0, 32'h0},        // R1 masked
    {4'd2, 1'b1, 12'h030, 32'h0000_0301, 32'h0},
    {4'd2, 1'b0, 12'h030, 32'h0, 32'h0000_0301}, // R2
    {4'd2, 1'b1, 12'h030, 32'hFFFF_FFFF, 32'h0},
    {4'd2, 1'b0, 12'h030, 32'h0, 32'h0000_FFFF}, // R2
    {4'd3, 1'b1, 12'h018, 32'hFF, 32'h0},
    {4'd3, 1'b0, 12'h018, 32'h0, 32'h0},         // R3 flag write ignored
    {4'd3, 1'b1, 12'h03C, 32'h30, 32'h0},
    {4'd3, 1'b0, 12'h03C, 32'h0, 32'h0},         // R3 raw write ignored
    {4'd3, 1'b1, 12'h048, 32'h7, 32'h0},
    {4'd3, 1'b0, 12'h048, 32'h0, 32'h0},         // R3 dma
    {4'd3, 1'b0, 12'h004, 32'h0, 32'h0},         // R3 rstat
    {4'd3, 1'b0, 12'h044, 32'h0, 32'h0},         // R3 clear reads 0
    {4'd3, 1'b1, 12'h00C, 32'h55, 32'h0},
    {4'd3, 1'b0, 12'h00C, 32'h0, 32'h0},         // R3 unmapped
    {4'd7, 1'b1, 12'h038, 32'h30, 32'h0},
    {4'd7, 1'b0, 12'h038, 32'h0, 32'h30},        // R7 mask
    {4'd7, 1'b0, 12'h040, 32'h0, 32'h0}          // R7 masked
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  task automatic host_push(input logic [7:0] d);
    @(negedge clk);
    rx_valid = 1'b1; rx_data = d;
    @(negedge clk);
    rx_valid = 1'b0;
  endtask

  task automatic host_pop(output logic [7:0] d);
    @(negedge clk);
    tx_ready = 1'b1;
    #1 d = tx_data;
    @(negedge clk);
    tx_ready = 1'b0;
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      summary();
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    logic [7:0]  b;
    int cnt, bad;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 irq", {31'b0, guest_irq}, 32'h0);
    check("R1 bell", {31'b0, host_bell}, 32'h0);
    check("R1 rx_ready", {31'b0, rx_ready}, 32'h1);
    check("R1 tx_valid", {31'b0, tx_valid}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      if (VECS[i][76]) bus_write(VECS[i][75:64], VECS[i][63:32]);
      else begin
        bus_read(VECS[i][75:64], r);
        check($sformatf("R%0d vec%0d", VECS[i][80:77], i), r, VECS[i][31:0]);
      end
    end
    check("R7 irq idle", {31'b0, guest_irq}, 32'h0);

    // R4 / R9 first byte into transmit queue
    bus_write(12'h000, 32'h41);
    check("R9 bell pulse", {31'b0, host_bell}, 32'h1);
    bus_read(12'h018, r);
    check("R9 bell drop", {31'b0, host_bell}, 32'h0);
    check("R4 flag after write", r, 32'h08);
    check("R10 tx_valid", {31'b0, tx_valid}, 32'h1);
    check("R10 tx_data", {24'b0, tx_data}, 32'h41);

    // R6 host pop empties transmit queue
    host_pop(b);
    check("R10 popped byte", {24'b0, b}, 32'h41);
    bus_read(12'h018, r); check("R6 flag after pop", r, 32'h80);
    bus_read(12'h03C, r); check("R6 raw after pop", r, 32'h20);
    bus_read(12'h040, r); check("R7 masked", r, 32'h20);
    check("R7 irq high", {31'b0, guest_irq}, 32'h1);

    // R8 clear
    bus_write(12'h044, 32'h20);
    bus_read(12'h03C, r); check("R8 raw cleared", r, 32'h0);
    check("R7 irq low", {31'b0, guest_irq}, 32'h0);

    // R6 receive pushes
    host_push(8'h5A);
    host_push(8'h5B);
    bus_read(12'h03C, r); check("R6 raw after push", r, 32'h30);
    bus_read(12'h018, r); check("R6 flag after push", r, 32'h80);
    bus_read(12'h000, r); check("R5 first byte", r, 32'h5A);
    bus_read(12'h03C, r); check("R5 raw nonempty", r, 32'h30);
    bus_read(12'h000, r); check("R5 second byte", r, 32'h5B);
    bus_read(12'h03C, r); check("R5 raw rx cleared", r, 32'h20);
    bus_read(12'h018, r); check("R5 rx empty flag", r, 32'h90);
    bus_read(12'h000, r); check("R5 empty read", r, 32'h0);

    // R9 no bell on second byte
    bus_write(12'h000, 32'h11);
    check("R9 bell first", {31'b0, host_bell}, 32'h1);
    bus_write(12'h000, 32'h22);
    check("R9 no bell second", {31'b0, host_bell}, 32'h0);
    host_pop(b); check("R10 order a", {24'b0, b}, 32'h11);
    host_pop(b); check("R10 order b", {24'b0, b}, 32'h22);

    // R11 / R4 fill transmit queue
    for (int i = 0; i < 2047; i++) bus_write(12'h000, 32'(i[7:0]));
    bus_read(12'h018, r); check("R4 full flag", r, 32'h38);
    bus_read(12'h03C, r); check("R4 raw tx cleared", r, 32'h0);
    bus_write(12'h000, 32'hEE);
    cnt = 0; bad = 0;
    while (tx_valid && cnt < 3000) begin
      host_pop(b);
      if (b !== 8'(cnt)) bad++;
      cnt++;
    end
    check("R11 tx depth", 32'(cnt), 32'd2047);
    check("R4 dropped write / order", 32'(bad), 32'd0);
    bus_read(12'h018, r); check("R6 tx drained flag", r, 32'h90);

    // R11 / R6 fill receive queue
    cnt = 0;
    while (rx_ready && cnt < 2000) begin
      host_push(8'(cnt + 3));
      cnt++;
    end
    check("R11 rx depth", 32'(cnt), 32'd1023);
    bus_read(12'h018, r); check("R6 rx full flag", r, 32'hC0);
    bus_read(12'h000, r); check("R5 oldest byte", r, 32'h03);
    bus_read(12'h018, r); check("R5 rx full cleared", r, 32'h80);
    for (int i = 0; i < 1021; i++) bus_read(12'h000, r);

    // R12 guest reads last byte while host pushes
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 12'h000;
    rx_valid = 1'b1; rx_data = 8'h77;
    @(negedge clk);
    bus_sel = 1'b0; rx_valid = 1'b0;
    bus_read(12'h018, r); check("R12 rx empty bit", {31'b0, r[4]}, 32'h0);
    bus_read(12'h03C, r); check("R12 raw rx bit", {31'b0, r[4]}, 32'h1);
    bus_read(12'h000, r); check("R12 byte kept", r, 32'h77);

    // R1 reset mid run
    @(negedge clk); rst_n = 1'b0;
    repeat (2) @(negedge clk); rst_n = 1'b1;
    bus_read(12'h018, r); check("R1 flag after reset", r, 32'h0);
    bus_read(12'h038, r); check("R1 mask after reset", r, 32'h0);
    check("R1 tx_valid after reset", {31'b0, tx_valid}, 32'h0);
    check("R1 irq after reset", {31'b0, guest_irq}, 32'h0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule